// File: doc/BRIEF.md
# Line-Fill Cacheability Controller

This block sits between the data cache and the external bus. It handles a data cache miss or a writethrough as one bus cycle. The core offers a request through a valid/ready handshake. A request carries its direction, its hit status, the page's cache-disable and writethrough attributes, and the line's present coherence state. A read that hits is answered at once, with no bus activity. Every other request opens a bus cycle.

At the start of the bus cycle the controller drives two attributes. The first is a page-uncacheable indication, which always mirrors the page's cache-disable attribute. The second is a burst-eligible indication, which is raised only for read misses on cacheable pages. Whether the cycle really is cacheable is settled later. The system answers with a cache-enable input, sampled together with a write-policy input on the first ready strobe of the cycle. A cacheable read becomes a burst of `BEATS` data transfers, and everything else completes on one transfer.

When the cycle ends, the controller pulses a completion flag to the core. With it comes the coherence state the core should use for the line, and a flag saying whether a line fill took place.

Top module: `linefill_ctrl`

## Requirements
- R1: For the whole of a bus cycle, `bus_pcd` equals the cache-disable attribute of the accepted request. Outside bus cycles it is 0.
- R2: `bus_cache` and `bus_pcd` are never 1 together. `bus_cache` is 1 during a bus cycle only for a read miss whose cache-disable attribute is 0.
- R3: `bus_cache` and `bus_pcd` take their values in the first cycle of the bus cycle and hold them to the end. `bus_ken` has no effect on them.
- R4: A read miss whose `bus_cache` or `bus_ken` is 0 at the first ready strobe completes on that strobe. `done` is 1 in the following cycle with `done_mesi` = Invalid and `done_install` = 0.
- R5: A read miss with `bus_cache` and `bus_ken` both 1 at the first ready strobe is a burst. It completes on the `BEATS`-th ready strobe (4 by default), and `done` and `done_install` are both 1 in the following cycle. Idle cycles between strobes are allowed.
- R6: The coherence state is coded Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. A burst fill reports Exclusive when the writethrough attribute is 0 and `bus_wbwt` was 1 at the first strobe. In every other case it reports Shared.
- R7: `bus_ken` and `bus_wbwt` are sampled only at the first ready strobe of a cycle. Changes on later strobes do not alter the outcome.
- R8: An accepted read hit starts no bus cycle. `done` is 1 in the next cycle, with `done_mesi` equal to the prior state and `done_install` = 0.
- R9: A write, whether hit or miss, runs as a single-transfer bus cycle with `bus_write` = 1 and `bus_cache` = 0. It completes on the first ready strobe and reports the prior state with `done_install` = 0.
- R10: `req_ready` is 1 exactly when no bus cycle is in progress. A request held valid during a cycle waits and is accepted after the cycle ends.
- R11: After reset, `req_ready` = 1, `bus_cycle` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hit | input | 1 | Request hits in the cache |
| req_page_nc | input | 1 | Page cache-disable attribute |
| req_page_wt | input | 1 | Page writethrough attribute |
| req_prior | input | 2 | Line's present coherence state |
| bus_cycle | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Current bus cycle is a write |
| bus_cache | output | 1 | Burst-eligible indication |
| bus_pcd | output | 1 | Page-uncacheable indication |
| bus_rdy | input | 1 | Data transfer ready strobe |
| bus_ken | input | 1 | System cache-enable answer |
| bus_wbwt | input | 1 | System write-policy answer |
| done | output | 1 | Completion pulse to the core |
| done_mesi | output | 2 | Resulting coherence state |
| done_install | output | 1 | A line fill was performed |

## Verification
The hardest case to reach is a burst in which `bus_ken` and `bus_wbwt` flip after the first strobe. In that case a design that resamples them gives a visibly different fill state. The stimulus inverts both inputs on every strobe after the first, and it spaces the strobes with idle cycles. A second hard case is a request held valid across a whole burst while its fields change. The stimulus does this and checks that the new request is taken only after completion.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_t;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_BUS  = 1'b1
    } ctl_t;

    typedef struct packed {
        logic  write;
        logic  hit;
        logic  nc;
        logic  wt;
        mesi_t prior;
    } lf_req_t;

    // Coherence state granted to a completed burst fill.
    function automatic mesi_t fill_state(input logic page_wt, input logic wbwt);
        return (!page_wt && wbwt) ? MESI_E : MESI_S;
    endfunction

    function automatic logic is_read_hit(input lf_req_t r);
        return r.hit && !r.write;
    endfunction

endpackage

// File: rtl/lf_attr.sv
module lf_attr (
    input  logic active,
    input  logic write,
    input  logic nc,
    output logic cache,
    output logic pcd,
    output logic wr
);
    // Uncacheable pages veto the burst indication; writes never burst.
    always_comb begin
        pcd   = active && nc;
        cache = active && !write && !nc;
        wr    = active && write;
    end
endmodule

// File: rtl/lf_beat_cnt.sv
module lf_beat_cnt #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic first,
    output logic last
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == LAST_IDX) ? '0 : cnt + CNT_W'(1);
        end
    end

    assign first = (cnt == '0);
    assign last  = (cnt == LAST_IDX);

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && last && !clear) |=> first); // R5
endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
    import lf_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  logic       req_hit,
    input  logic       req_page_nc,
    input  logic       req_page_wt,
    input  logic [1:0] req_prior,
    output logic       bus_cycle,
    output logic       bus_write,
    output logic       bus_cache,
    output logic       bus_pcd,
    input  logic       bus_rdy,
    input  logic       bus_ken,
    input  logic       bus_wbwt,
    output logic       done,
    output logic [1:0] done_mesi,
    output logic       done_install
);
    ctl_t    state;
    lf_req_t req_in, req_q;
    logic    burst_q, wbwt_q;
    mesi_t   mesi_q;

    logic accept, hit_read, rdy_act, beat_first, beat_last;
    logic take_burst, finish_single, finish_burst, cnt_step;

    assign req_in = '{write: req_write, hit: req_hit, nc: req_page_nc,
                      wt: req_page_wt, prior: mesi_t'(req_prior)};

    assign req_ready = (state == CTL_IDLE);
    assign bus_cycle = (state == CTL_BUS);
    assign accept    = req_valid && req_ready;
    assign hit_read  = is_read_hit(req_in);

    lf_attr u_attr (
        .active (bus_cycle),
        .write  (req_q.write),
        .nc     (req_q.nc),
        .cache  (bus_cache),
        .pcd    (bus_pcd),
        .wr     (bus_write)
    );

    // Cacheability is settled on the first strobe, from the driven
    // burst indication and the system's answer at that moment.
    assign rdy_act       = bus_cycle && bus_rdy;
    assign take_burst    = rdy_act && beat_first && bus_cache && bus_ken;
    assign finish_single = rdy_act && beat_first && !(bus_cache && bus_ken);
    assign finish_burst  = rdy_act && !beat_first && beat_last;
    assign cnt_step      = take_burst || (rdy_act && !beat_first);

    lf_beat_cnt #(.BEATS(BEATS)) u_beats (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (cnt_step),
        .first (beat_first),
        .last  (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= CTL_IDLE;
            req_q        <= '0;
            burst_q      <= 1'b0;
            wbwt_q       <= 1'b0;
            done         <= 1'b0;
            mesi_q       <= MESI_I;
            done_install <= 1'b0;
        end else begin
            done         <= 1'b0;
            done_install <= 1'b0;
            unique case (state)
                CTL_IDLE: begin
                    if (accept) begin
                        req_q <= req_in;
                        if (hit_read) begin
                            done   <= 1'b1;
                            mesi_q <= req_in.prior;
                        end else begin
                            state   <= CTL_BUS;
                            burst_q <= 1'b0;
                        end
                    end
                end
                CTL_BUS: begin
                    if (take_burst) begin
                        burst_q <= 1'b1;
                        wbwt_q  <= bus_wbwt;
                    end
                    if (finish_single) begin
                        state  <= CTL_IDLE;
                        done   <= 1'b1;
                        mesi_q <= req_q.write ? req_q.prior : MESI_I;
                    end
                    if (finish_burst) begin
                        state        <= CTL_IDLE;
                        done         <= 1'b1;
                        done_install <= 1'b1;
                        mesi_q       <= fill_state(req_q.wt, wbwt_q);
                    end
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end

    assign done_mesi = mesi_q;

    AST_PCD_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit_read) |=> (bus_pcd == $past(req_page_nc))); // R1
    AST_CACHE_PCD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_cache && bus_pcd)); // R2
    AST_ATTR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_cycle && $past(bus_cycle)) |-> ($stable(bus_cache) && $stable(bus_pcd))); // R3
    AST_NC_INVALID: assert property (@(posedge clk) disable iff (rst)
        (finish_single && !req_q.write) |=> (done && done_mesi == MESI_I && !done_install)); // R4
    AST_INSTALL_BURST: assert property (@(posedge clk) disable iff (rst)
        done_install |-> $past(burst_q)); // R5
    AST_WBWT_HELD: assert property (@(posedge clk) disable iff (rst)
        (burst_q && bus_cycle && $past(burst_q && bus_cycle)) |-> $stable(wbwt_q)); // R7
    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (accept && hit_read) |=> (!bus_cycle && done)); // R8
    AST_WRITE_UNCACHED: assert property (@(posedge clk) disable iff (rst)
        bus_write |-> !bus_cache); // R9
    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
        bus_cycle |-> !req_ready); // R10
endmodule

// File: tb/tb_linefill_ctrl.sv
module tb_linefill_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_hit = 0, req_page_nc = 0, req_page_wt = 0;
    logic [1:0] req_prior = 2'b00;
    logic bus_rdy = 0, bus_ken = 0, bus_wbwt = 0;
    logic req_ready, bus_cycle, bus_write, bus_cache, bus_pcd, done, done_install;
    logic [1:0] done_mesi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    linefill_ctrl #(.BEATS(4)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_hit(req_hit), .req_page_nc(req_page_nc),
        .req_page_wt(req_page_wt), .req_prior(req_prior), .bus_cycle(bus_cycle),
        .bus_write(bus_write), .bus_cache(bus_cache), .bus_pcd(bus_pcd),
        .bus_rdy(bus_rdy), .bus_ken(bus_ken), .bus_wbwt(bus_wbwt),
        .done(done), .done_mesi(done_mesi), .done_install(done_install)
    );

    // Behavioural reference model
    logic m_busy = 0, m_first = 0, m_wb = 0, m_done = 0, m_inst = 0;
    logic m_w = 0, m_nc = 0, m_wt = 0;
    logic [1:0] m_prior = 0, m_mesi = 0;
    int m_beats = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_first <= 0; m_done <= 0; m_inst <= 0; m_mesi <= 0;
            m_w <= 0; m_nc <= 0; m_wt <= 0; m_prior <= 0; m_beats <= 0;
        end else begin
            m_done <= 0;
            m_inst <= 0;
            if (!m_busy) begin
                if (req_valid) begin
                    if (req_hit && !req_write) begin
                        m_done <= 1; m_mesi <= req_prior;
                    end else begin
                        m_busy <= 1; m_first <= 1; m_beats <= 0;
                        m_w <= req_write; m_nc <= req_page_nc;
                        m_wt <= req_page_wt; m_prior <= req_prior;
                    end
                end
            end else if (bus_rdy) begin
                if (m_first) begin
                    if (!m_w && !m_nc && bus_ken) begin
                        m_first <= 0; m_wb <= bus_wbwt; m_beats <= 1;
                    end else begin
                        m_busy <= 0; m_done <= 1;
                        m_mesi <= m_w ? m_prior : 2'b00;
                    end
                end else if (m_beats == 3) begin
                    m_busy <= 0; m_done <= 1; m_inst <= 1;
                    m_mesi <= (!m_wt && m_wb) ? 2'b10 : 2'b01;
                end else begin
                    m_beats <= m_beats + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(req_ready == !m_busy, "R10 req_ready", {7'd0, req_ready}, {7'd0, !m_busy});
            chk(bus_cycle == m_busy, "R8 bus_cycle", {7'd0, bus_cycle}, {7'd0, m_busy});
            chk(bus_pcd == (m_busy && m_nc), "R1 bus_pcd", {7'd0, bus_pcd}, {7'd0, m_busy && m_nc});
            chk(bus_cache == (m_busy && !m_w && !m_nc), "R2 R3 bus_cache",
                {7'd0, bus_cache}, {7'd0, m_busy && !m_w && !m_nc});
            chk(!(bus_cache && bus_pcd), "R2 exclusive", {6'd0, bus_cache, bus_pcd}, 8'd0);
            chk(bus_write == (m_busy && m_w), "R9 bus_write", {7'd0, bus_write}, {7'd0, m_busy && m_w});
            chk(done == m_done, "R5 done", {7'd0, done}, {7'd0, m_done});
            if (m_done) begin
                chk(done_mesi == m_mesi, "R6 R7 R8 done_mesi", {6'd0, done_mesi}, {6'd0, m_mesi});
                chk(done_install == m_inst, "R4 R5 done_install", {7'd0, done_install}, {7'd0, m_inst});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One request; strobes gap out when gappy; ken/wbwt invert after first strobe (R7)
    task automatic run(input logic w, input logic h, input logic nc, input logic wt,
                       input logic [1:0] prior, input logic ken, input logic wbwt, input bit gappy);
        @(negedge clk);
        req_valid = 1; req_write = w; req_hit = h; req_page_nc = nc;
        req_page_wt = wt; req_prior = prior;
        bus_ken = ken; bus_wbwt = wbwt; bus_rdy = 0;
        @(negedge clk);
        req_valid = 0;
        while (m_busy) begin
            bus_rdy = gappy ? ~bus_rdy : 1'b1;
            bus_ken = m_first ? ken : ~ken;
            bus_wbwt = m_first ? wbwt : ~wbwt;
            @(negedge clk);
        end
        bus_rdy = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: state after reset
        chk(req_ready == 1, "R11 req_ready", {7'd0, req_ready}, 8'd1);
        chk(bus_cycle == 0, "R11 bus_cycle", {7'd0, bus_cycle}, 8'd0);
        chk(done == 0, "R11 done", {7'd0, done}, 8'd0);

        run(0, 1, 0, 0, 2'b10, 1, 1, 0);  // R8 read hit, Exclusive kept
        run(0, 1, 1, 1, 2'b11, 0, 0, 0);  // R8 read hit, Modified kept
        run(0, 0, 0, 0, 2'b00, 1, 1, 0);  // R5 R6 burst -> Exclusive
        run(0, 0, 0, 0, 2'b00, 1, 0, 1);  // R6 wbwt low -> Shared, gapped strobes
        run(0, 0, 0, 1, 2'b00, 1, 1, 1);  // R6 writethrough page -> Shared
        run(0, 0, 0, 0, 2'b00, 0, 1, 0);  // R4 ken low -> single, Invalid
        run(0, 0, 1, 0, 2'b00, 1, 1, 0);  // R1 R2 R4 uncacheable page
        run(1, 0, 0, 0, 2'b00, 1, 1, 0);  // R9 write miss
        run(1, 1, 1, 0, 2'b01, 1, 1, 1);  // R9 write hit to shared line
        run(0, 0, 0, 0, 2'b00, 1, 1, 1);  // R7 later strobes invert ken/wbwt

        // R10: request held valid through a burst, fields changed mid-cycle
        @(negedge clk);
        req_valid = 1; req_write = 0; req_hit = 0; req_page_nc = 0;
        req_page_wt = 0; req_prior = 2'b00; bus_ken = 1; bus_wbwt = 1;
        @(negedge clk);
        req_write = 1; req_prior = 2'b01;
        while (m_busy) begin
            bus_rdy = 1;
            @(negedge clk);
        end
        bus_rdy = 0;
        @(negedge clk);
        req_valid = 0;
        chk(bus_write == 1, "R10 stalled request taken after cycle", {7'd0, bus_write}, 8'd1);
        while (m_busy) begin
            bus_rdy = 1;
            @(negedge clk);
        end
        bus_rdy = 0;

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule